// File: doc/BRIEF.md
# Fragmented Message Reassembly Controller

This block takes received data frames one at a time and rebuilds a multi-frame transport-layer message inside a message buffer RAM. Each frame supplies a length code (DLC) and up to eight data bytes. The first data byte is a header that drives the assembly state machine. The remaining bytes are user data. The block appends them at a running offset, starting at buffer byte 1.

Buffer byte 0 is a length slot. It is cleared to 00h when a message opens. It receives the total byte count only when the final frame has been stored, and in that same cycle a one-cycle completion pulse is raised.

A mode input picks how the header is read. Three protocol modes are available:
- fragment type plus a 6-bit fragment count;
- consecutive frames carrying a 4-bit sequence number;
- segmented download with a toggle bit and a last-segment flag.

Headers that break the rules, and messages that would grow past 255 bytes, raise a one-cycle error pulse and drop the partial message.

Top module: `msg_reasm`

## Requirements
- R1: After reset, no buffer write, no completion pulse and no error pulse are produced until a frame arrives.
- R2: In mode 0 (fragment mode), header bits [7:6] are the type and bits [5:0] are the count. A frame with type 00 and count 0 opens a message. The block writes 00h to byte 0, then writes data bytes 2..DLC to buffer bytes 1 and upward, in order.
- R3: In mode 0, type 01 is a middle fragment and type 10 is the last fragment. Either one is accepted only while a message is open and only if its count equals the previous count plus one (modulo 64). Its data is appended at the running offset. After the data of a last fragment is stored, byte 0 is written with the total count and the completion pulse is high for exactly one cycle.
- R4: In mode 0, a frame with type 00 and count 3Fh is a complete message in one frame. The block clears byte 0, stores the data, then writes the count to byte 0 and pulses completion.
- R5: In mode 0, each of the following pulses error and closes any open message:
  - a count out of order;
  - type 11;
  - type 00 with a count other than 0 or 3Fh;
  - a middle or last fragment with no message open.

  A later last fragment then does not complete.
- R6: In mode 1 (consecutive-frame mode), header bits [7:4] must be 0010b and bits [3:0] are the sequence number. With no message open, sequence 1 opens one. Each next frame must carry the previous sequence plus one (modulo 16). A frame with DLC 8 continues the message and a frame with DLC below 8 ends it.
- R7: In mode 1, a wrong high nibble or a sequence out of order pulses error and closes any open message.
- R8: In mode 2 (segment mode), header bit 4 is a toggle and bit 0 marks the last segment. The opening segment has toggle 0, and each later segment must carry the inverse of the previous toggle. A segment with bit 0 set completes the message.
- R9: In mode 2, a toggle that does not alternate, or an opening segment with toggle 1, pulses error and closes any open message.
- R10: A frame that would make the stored length exceed 255 bytes pulses error, writes none of its data and abandons the message. A message that reaches exactly 255 completes with count 255.
- R11: Frames in mode 3, and frames with DLC 0, are ignored: they cause no write and no pulse.
- R12: In mode 0, an opening fragment that arrives while a message is open restarts assembly at buffer byte 1 without an error pulse.
- R13: A final frame that would complete a message of zero bytes pulses error instead of completing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_valid_i | input | 1 | One-cycle strobe: a received frame is present |
| mode_i | input | 2 | Header format: 0 fragment, 1 consecutive, 2 segment, 3 off |
| dlc_i | input | 4 | Frame length code (values above 8 treated as 8) |
| frame_data_i | input | 64 | Frame data; data byte k (1..8) in bits [8k-1:8k-8] |
| wr_en_o | output | 1 | Buffer RAM write enable |
| wr_addr_o | output | 8 | Buffer RAM byte address |
| wr_data_o | output | 8 | Buffer RAM write data |
| msg_done_o | output | 1 | One-cycle pulse: message stored and count written |
| msg_err_o | output | 1 | One-cycle pulse: message error |

## Verification
The checks assume that a frame strobe never arrives while the controller is still writing the previous frame. A frame can occupy the controller for up to nine cycles: a clear, seven data bytes, and a count write. The stimulus therefore drives each frame on a falling edge, holds the strobe for one cycle, and then waits fourteen cycles before the next frame. Under that spacing, successive data writes form runs of consecutive addresses, and every completion coincides with a nonzero count written to byte 0.

// File: rtl/reasm_pkg.sv
package reasm_pkg;
  typedef enum logic [1:0] {
    MODE_FRAG = 2'd0,
    MODE_CSEQ = 2'd1,
    MODE_SEG  = 2'd2,
    MODE_OFF  = 2'd3
  } mode_e;

  typedef struct packed {
    logic ign;
    logic err;
    logic start;
    logic append;
    logic last;
  } act_t;
endpackage

// File: rtl/reasm_decode.sv
module reasm_decode
  import reasm_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int LEN_W      = 8,
  localparam int DLC_W     = 4
) (
  input  logic [1:0]       mode_i,
  input  logic [DLC_W-1:0] dlc_i,
  input  logic [7:0]       hdr_i,
  input  logic             active_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [5:0]       cnt_i,
  input  logic [3:0]       seq_i,
  input  logic             tog_i,
  output act_t             act_o,
  output logic [DLC_W-1:0] ndata_o
);
  localparam logic [LEN_W:0] MAX_LEN = (LEN_W+1)'((1 << LEN_W) - 1);

  logic [DLC_W-1:0] dlc_eff;
  logic             ok, st, lst;
  logic [LEN_W:0]   sum;

  always_comb begin
    dlc_eff = (dlc_i > DLC_W'(DATA_BYTES)) ? DLC_W'(DATA_BYTES) : dlc_i;
    ndata_o = (dlc_eff == '0) ? '0 : dlc_eff - 1'b1;
    ok  = 1'b0;
    st  = 1'b0;
    lst = 1'b0;
    act_o = '0;

    unique case (mode_e'(mode_i))
      MODE_FRAG: begin
        unique case (hdr_i[7:6])
          2'b00: begin
            st  = 1'b1;
            ok  = (hdr_i[5:0] == 6'd0) || (hdr_i[5:0] == 6'h3f);
            lst = (hdr_i[5:0] == 6'h3f);
          end
          2'b01: ok = active_i && (hdr_i[5:0] == 6'(cnt_i + 6'd1));
          2'b10: begin
            ok  = active_i && (hdr_i[5:0] == 6'(cnt_i + 6'd1));
            lst = 1'b1;
          end
          default: ok = 1'b0;
        endcase
      end
      MODE_CSEQ: begin
        lst = (dlc_eff < DLC_W'(DATA_BYTES));
        if (hdr_i[7:4] == 4'b0010) begin
          if (!active_i) begin
            st = 1'b1;
            ok = (hdr_i[3:0] == 4'd1);
          end else begin
            ok = (hdr_i[3:0] == 4'(seq_i + 4'd1));
          end
        end
      end
      MODE_SEG: begin
        lst = hdr_i[0];
        if (!active_i) begin
          st = 1'b1;
          ok = !hdr_i[4];
        end else begin
          ok = (hdr_i[4] != tog_i);
        end
      end
      default: ok = 1'b0;
    endcase

    sum = (st ? '0 : {1'b0, len_i}) + (LEN_W+1)'(ndata_o);

    if (mode_e'(mode_i) == MODE_OFF || dlc_eff == '0) begin
      act_o.ign = 1'b1;
    end else if (!ok || sum > MAX_LEN || (lst && sum == '0)) begin
      act_o.err = 1'b1;
    end else begin
      act_o.start  = st;
      act_o.append = !st;
      act_o.last   = lst;
    end
  end
endmodule

// File: rtl/reasm_ctrl.sv
module reasm_ctrl
  import reasm_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int LEN_W      = 8,
  localparam int DLC_W     = 4,
  localparam int SEL_W     = $clog2(DATA_BYTES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      frame_valid_i,
  input  logic [8*DATA_BYTES-1:0]   frame_data_i,
  input  act_t                      act_i,
  input  logic [DLC_W-1:0]          ndata_i,
  output logic                      active_o,
  output logic [LEN_W-1:0]          len_o,
  output logic [5:0]                cnt_o,
  output logic [3:0]                seq_o,
  output logic                      tog_o,
  output logic                      busy_o,
  output logic                      wr_en_o,
  output logic [LEN_W-1:0]          wr_addr_o,
  output logic [7:0]                wr_data_o,
  output logic                      done_o,
  output logic                      err_o
);
  typedef enum logic [1:0] {S_IDLE, S_CLR, S_DATA, S_FIN} state_e;

  state_e                         state_q;
  logic [DATA_BYTES-1:0][7:0]     data_q;
  logic [DLC_W-1:0]               ndata_q, idx_q;
  logic                           last_q;
  logic [SEL_W-1:0]               sel;

  // next state once the frame's data (if any) is stored
  function automatic state_e after_data(logic [DLC_W-1:0] n, logic lst);
    if (n != '0) return S_DATA;
    return lst ? S_FIN : S_IDLE;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      data_q   <= '0;
      ndata_q  <= '0;
      idx_q    <= '0;
      last_q   <= 1'b0;
      active_o <= 1'b0;
      len_o    <= '0;
      cnt_o    <= '0;
      seq_o    <= '0;
      tog_o    <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      err_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (frame_valid_i && !act_i.ign) begin
          if (act_i.err) begin
            err_o    <= 1'b1;
            active_o <= 1'b0;
          end else begin
            data_q   <= frame_data_i;
            ndata_q  <= ndata_i;
            idx_q    <= '0;
            last_q   <= act_i.last;
            cnt_o    <= frame_data_i[5:0];
            seq_o    <= frame_data_i[3:0];
            tog_o    <= frame_data_i[4];
            active_o <= 1'b1;
            if (act_i.start) begin
              len_o   <= '0;
              state_q <= S_CLR;
            end else begin
              state_q <= after_data(ndata_i, act_i.last);
            end
          end
        end
        S_CLR: state_q <= after_data(ndata_q, last_q);
        S_DATA: begin
          len_o <= len_o + 1'b1;
          idx_q <= idx_q + 1'b1;
          if (idx_q == ndata_q - 1'b1) state_q <= last_q ? S_FIN : S_IDLE;
        end
        S_FIN: begin
          active_o <= 1'b0;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign sel = SEL_W'(idx_q + 1'b1);

  always_comb begin
    wr_en_o   = 1'b0;
    wr_addr_o = '0;
    wr_data_o = '0;
    done_o    = 1'b0;
    unique case (state_q)
      S_CLR:  wr_en_o = 1'b1;
      S_DATA: begin
        wr_en_o   = 1'b1;
        wr_addr_o = len_o + 1'b1;
        wr_data_o = data_q[sel];
      end
      S_FIN: begin
        wr_en_o   = 1'b1;
        wr_data_o = 8'(len_o);
        done_o    = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy_o = (state_q != S_IDLE);
endmodule

// File: rtl/msg_reasm.sv
module msg_reasm
  import reasm_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int LEN_W      = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    frame_valid_i,
  input  logic [1:0]              mode_i,
  input  logic [3:0]              dlc_i,
  input  logic [8*DATA_BYTES-1:0] frame_data_i,
  output logic                    wr_en_o,
  output logic [LEN_W-1:0]        wr_addr_o,
  output logic [7:0]              wr_data_o,
  output logic                    msg_done_o,
  output logic                    msg_err_o
);
  act_t             act;
  logic [3:0]       ndata;
  logic             active;
  logic [LEN_W-1:0] len;
  logic [5:0]       cnt;
  logic [3:0]       seq;
  logic             tog;
  logic             busy;

  reasm_decode #(.DATA_BYTES(DATA_BYTES), .LEN_W(LEN_W)) u_decode (
    .mode_i   (mode_i),
    .dlc_i    (dlc_i),
    .hdr_i    (frame_data_i[7:0]),
    .active_i (active),
    .len_i    (len),
    .cnt_i    (cnt),
    .seq_i    (seq),
    .tog_i    (tog),
    .act_o    (act),
    .ndata_o  (ndata)
  );

  reasm_ctrl #(.DATA_BYTES(DATA_BYTES), .LEN_W(LEN_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_valid_i (frame_valid_i),
    .frame_data_i  (frame_data_i),
    .act_i         (act),
    .ndata_i       (ndata),
    .active_o      (active),
    .len_o         (len),
    .cnt_o         (cnt),
    .seq_o         (seq),
    .tog_o         (tog),
    .busy_o        (busy),
    .wr_en_o       (wr_en_o),
    .wr_addr_o     (wr_addr_o),
    .wr_data_o     (wr_data_o),
    .done_o        (msg_done_o),
    .err_o         (msg_err_o)
  );
endmodule

// File: rtl/reasm_chk.sv
module reasm_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_valid_i,
  input logic             busy,
  input logic             wr_en_o,
  input logic [LEN_W-1:0] wr_addr_o,
  input logic [7:0]       wr_data_o,
  input logic             msg_done_o,
  input logic             msg_err_o
);
  // input assumption: no frame while a previous one is being written
  frame_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i |-> !busy);

  // R3 R4 R13
  done_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_done_o |-> (wr_en_o && wr_addr_o == '0 && wr_data_o != 8'd0));

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_done_o |=> !msg_done_o);

  // R5
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_err_o |=> !msg_err_o);

  // R5
  err_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(msg_err_o && msg_done_o));

  // R2
  append_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o != '0 && $past(wr_en_o) && $past(wr_addr_o) != '0)
      |-> wr_addr_o == $past(wr_addr_o) + 1'b1);
endmodule

bind msg_reasm reasm_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_valid_i (frame_valid_i),
  .busy          (busy),
  .wr_en_o       (wr_en_o),
  .wr_addr_o     (wr_addr_o),
  .wr_data_o     (wr_data_o),
  .msg_done_o    (msg_done_o),
  .msg_err_o     (msg_err_o)
);

// File: tb/msg_reasm_bench.sv
module msg_reasm_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_valid_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [3:0]  dlc_i = 4'd0;
  logic [63:0] frame_data_i = '0;
  logic        wr_en_o;
  logic [7:0]  wr_addr_o, wr_data_o;
  logic        msg_done_o, msg_err_o;

  int checks = 0, errors = 0;
  int n_wr = 0, n_done = 0, n_err = 0;
  logic [7:0] mem [256];

  always #10 clk_i = ~clk_i;

  msg_reasm u_msg_reasm (.*);

  always @(negedge clk_i) if (rst_ni) begin
    if (wr_en_o) begin
      mem[wr_addr_o] = wr_data_o;
      n_wr++;
    end
    if (msg_done_o) n_done++;
    if (msg_err_o) n_err++;
  end

  function automatic logic [7:0] pat(int p);
    return 8'(p) ^ 8'hA5;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    n_wr = 0; n_done = 0; n_err = 0;
  endtask

  // frame whose user data lands at buffer positions pos..
  task automatic frm(logic [1:0] m, logic [7:0] hdr, int dlc, int pos);
    logic [63:0] d = '0;
    d[7:0] = hdr;
    for (int i = 1; i < dlc && i < 8; i++) d[8*i +: 8] = pat(pos + i - 1);
    @(negedge clk_i);
    mode_i = m; dlc_i = 4'(dlc); frame_data_i = d; frame_valid_i = 1'b1;
    @(negedge clk_i);
    frame_valid_i = 1'b0;
    repeat (14) @(negedge clk_i);
  endtask

  task automatic chk_buf(string tag, int n);
    int bad = 0;
    for (int i = 1; i <= n; i++) if (mem[i] != pat(i)) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk("R1 wr_en", int'(wr_en_o), 0);
    chk("R1 pulses", int'(msg_done_o) + int'(msg_err_o), 0);
    chk("R1 writes", n_wr, 0);
  endtask

  task automatic t_frag_multi();
    clr();
    frm(2'd0, 8'h00, 8, 1);
    chk("R2 byte0 cleared", int'(mem[0]), 0);
    chk_buf("R2 first data", 7);
    chk("R3 no early done", n_done, 0);
    frm(2'd0, 8'h41, 8, 8);
    frm(2'd0, 8'h82, 3, 15);
    chk_buf("R3 appended data", 16);
    chk("R3 count", int'(mem[0]), 16);
    chk("R3 done pulse", n_done, 1);
    chk("R3 no err", n_err, 0);
  endtask

  task automatic t_frag_single();
    clr();
    frm(2'd0, 8'h3F, 5, 1);
    chk_buf("R4 data", 4);
    chk("R4 count", int'(mem[0]), 4);
    chk("R4 done", n_done, 1);
  endtask

  task automatic t_frag_bad();
    clr();
    frm(2'd0, 8'h00, 4, 1);
    frm(2'd0, 8'h42, 4, 4);
    chk("R5 gap err", n_err, 1);
    frm(2'd0, 8'h82, 4, 4);
    chk("R5 orphan last err", n_err, 2);
    chk("R5 no done", n_done, 0);
    frm(2'd0, 8'hC0, 4, 1);
    frm(2'd0, 8'h05, 4, 1);
    chk("R5 bad type err", n_err, 4);
    chk("R5 writes", n_wr, 4);
  endtask

  task automatic t_restart();
    clr();
    frm(2'd0, 8'h00, 8, 101);
    frm(2'd0, 8'h00, 4, 1);
    frm(2'd0, 8'h81, 2, 4);
    chk_buf("R12 data", 4);
    chk("R12 count", int'(mem[0]), 4);
    chk("R12 done no err", n_done * 10 + n_err, 10);
  endtask

  task automatic t_cseq();
    int pos = 1;
    clr();
    for (int k = 1; k <= 17; k++) begin
      frm(2'd1, {4'b0010, 4'(k)}, 8, pos);
      pos += 7;
    end
    chk("R6 no early done", n_done, 0);
    frm(2'd1, 8'h22, 3, pos);
    chk_buf("R6 data", 121);
    chk("R6 count", int'(mem[0]), 121);
    chk("R6 done", n_done, 1);
  endtask

  task automatic t_cseq_bad();
    clr();
    frm(2'd1, 8'h31, 8, 1);
    chk("R7 nibble err", n_err, 1);
    frm(2'd1, 8'h21, 8, 1);
    frm(2'd1, 8'h23, 8, 8);
    chk("R7 seq err", n_err, 2);
    frm(2'd1, 8'h22, 3, 8);
    chk("R7 discarded", n_done * 10 + n_err, 3);
  endtask

  task automatic t_seg();
    clr();
    frm(2'd2, 8'h00, 8, 1);
    frm(2'd2, 8'h10, 8, 8);
    frm(2'd2, 8'h01, 4, 15);
    chk_buf("R8 data", 17);
    chk("R8 count", int'(mem[0]), 17);
    chk("R8 done", n_done, 1);
  endtask

  task automatic t_seg_bad();
    clr();
    frm(2'd2, 8'h10, 8, 1);
    chk("R9 start toggle err", n_err, 1);
    frm(2'd2, 8'h00, 8, 1);
    frm(2'd2, 8'h01, 8, 8);
    chk("R9 repeat toggle err", n_err, 2);
    chk("R9 no done", n_done, 0);
  endtask

  task automatic t_overflow(int last_dlc, int exp_ok);
    int pos = 1;
    int w0;
    clr();
    frm(2'd0, 8'h00, 8, pos);
    pos += 7;
    for (int k = 1; k <= 35; k++) begin
      frm(2'd0, {2'b01, 6'(k)}, 8, pos);
      pos += 7;
    end
    w0 = n_wr;
    frm(2'd0, {2'b10, 6'd36}, last_dlc, pos);
    if (exp_ok != 0) begin
      chk_buf("R10 full data", 255);
      chk("R10 count 255", int'(mem[0]), 255);
      chk("R10 done", n_done, 1);
    end else begin
      chk("R10 overflow err", n_err, 1);
      chk("R10 no writes", n_wr - w0, 0);
      chk("R10 no done", n_done, 0);
    end
  endtask

  task automatic t_ignore();
    clr();
    frm(2'd3, 8'h3F, 8, 1);
    frm(2'd0, 8'h3F, 0, 1);
    chk("R11 no writes", n_wr, 0);
    chk("R11 no pulses", n_done + n_err, 0);
  endtask

  task automatic t_zero();
    clr();
    frm(2'd0, 8'h3F, 1, 1);
    chk("R13 err", n_err, 1);
    chk("R13 no done no write", n_done + n_wr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_frag_multi();
    t_frag_single();
    t_frag_bad();
    t_restart();
    t_cseq();
    t_cseq_bad();
    t_seg();
    t_seg_bad();
    t_overflow(5, 0);
    t_overflow(4, 1);
    t_ignore();
    t_zero();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule